// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

A twelve-pin general-purpose I/O block with a 32-bit word-addressed register interface. Software selects a direction for every pin, writes the level that output pins drive, and reads the synchronized level of every pin whatever its direction. Each pin can also watch its input for an event: a rising edge, a falling edge, either edge, a low level or a high level. An event latches into a sticky status bit, but only while that pin's interrupt enable is set. A per-pin mask hides status bits from a single combined interrupt output.

Inputs pass through a two-flop synchronizer. Edge detection compares the synchronized level with its value one cycle earlier. Status bits are cleared by writing ones. A level-mode bit whose condition still holds sets again in the same cycle it is cleared. The mask has two write-one ports, one that sets bits and one that clears them. A soft reset is started by writing 1 and then 0 to the reset word. A small state machine with two states follows this sequence. In SR_IDLE, writing bit 0 = 1 takes the transition ARM to SR_ARMED. In SR_ARMED, writing bit 0 = 0 takes the transition FIRE back to SR_IDLE and returns every register to its default. Any other access leaves the state where it is.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every readable word reads 0, pin_oe and pin_out are 0 and irq is low.
- R2: Word 0x20 holds the direction: bit p = 1 drives pin_oe[p] high (output), 0 makes the pin an input. Word 0x18 holds the output levels, presented on pin_out. Both take effect in the cycle after the write.
- R3: Word 0x1C reads the synchronized level of all 12 pins regardless of direction. A change on pin_in becomes visible there after two rising clock edges.
- R4: Trigger codes are 3 bits: 0 = falling edge, 1 = rising edge, 2 = low level, 3 = high level, 4 = either edge. Codes 5 to 7 never raise an event. Pin p < 8 uses bits [4p+2:4p] of word 0x24. Pin p >= 8 uses bits [4(p-8)+2:4(p-8)] of word 0x28. Bit 3 of every nibble reads 0.
- R5: An event sets status bit p (word 0x04) only while enable bit p (word 0x00) is set. Once set, the bit stays set until it is cleared.
- R6: Clearing a level-mode status bit while its level condition still holds leaves it set.
- R7: Writing word 0x0C clears each status bit written as 1. Bits written as 0 are untouched.
- R8: Writing word 0x10 sets each mask bit written as 1. Writing word 0x14 clears each mask bit written as 1. Reading 0x10 returns the mask.
- R9: Word 0x08 reads status AND NOT mask, and irq is high exactly when that value is nonzero.
- R10: Word 0x3C is the soft reset. Writing 1 arms it and it then reads 1. A following write of 0 clears the enable, status, mask, output, direction and trigger registers. A write of 0 that does not follow an arming write changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 6 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | 12 | Pin levels from the pads |
| pin_out | output | 12 | Output levels to the pads |
| pin_oe | output | 12 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Every cycle, the assertions check four things. A status bit never rises on a pin whose enable was clear. A set status bit only falls through a clearing write or a soft reset. A mask-set write always leaves the written bits set. A FIRE transition leaves the enable, mask and direction registers empty. Per pin, they also check that codes 5 to 7 never produce an event. Only the bench's scenarios can show the rest: the two-edge synchronizer latency, each trigger code reacting to its own pattern, a level bit setting again while it is being cleared, the masked view driving irq, and a write of 0 to the reset word that is ignored when SR_ARMED was not entered first.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Word indices (byte address >> 2)
    localparam int W_IEN   = 0;
    localparam int W_STAT  = 1;
    localparam int W_DISP  = 2;
    localparam int W_CLR   = 3;
    localparam int W_MSET  = 4;
    localparam int W_MCLR  = 5;
    localparam int W_OUT   = 6;
    localparam int W_IN    = 7;
    localparam int W_DIR   = 8;
    localparam int W_MODE0 = 9;
    localparam int W_SRST  = 15;

    // Trigger codes
    localparam logic [2:0] TRIG_FALL = 3'd0;
    localparam logic [2:0] TRIG_RISE = 3'd1;
    localparam logic [2:0] TRIG_LOW  = 3'd2;
    localparam logic [2:0] TRIG_HIGH = 3'd3;
    localparam logic [2:0] TRIG_BOTH = 3'd4;

    localparam int PINS_PER_MODE_WORD = 8;

    typedef enum logic {
        SR_IDLE  = 1'b0,
        SR_ARMED = 1'b1
    } srst_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q_out
);
    logic [N-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
    import gpio_irq_pkg::*;
#(
    parameter int N = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lvl,
    input  logic [3*N-1:0] mode_flat,
    output logic [N-1:0]   evt
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic [2:0] code;
        logic       rise;
        logic       fall;

        assign code = mode_flat[3*p +: 3];
        assign rise = lvl[p] & ~prev_q[p];
        assign fall = ~lvl[p] & prev_q[p];

        always_comb begin
            case (code)
                TRIG_FALL: evt[p] = fall;
                TRIG_RISE: evt[p] = rise;
                TRIG_LOW:  evt[p] = ~lvl[p];
                TRIG_HIGH: evt[p] = lvl[p];
                TRIG_BOTH: evt[p] = rise | fall;
                default:   evt[p] = 1'b0;
            endcase
        end

        // R4
        bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code > TRIG_BOTH) |-> !evt[p]);
    end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int N  = 12,
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [N-1:0]   evt,
    input  logic [N-1:0]   lvl,
    output logic [3*N-1:0] mode_flat,
    output logic [N-1:0]   pin_out,
    output logic [N-1:0]   pin_oe,
    output logic           irq
);
    localparam int WORD_W = AW - 2;

    logic [WORD_W-1:0] word;
    logic [N-1:0] ien_q, status_q, mask_q, out_q, dir_q;
    logic [N-1:0] clr_bits, status_d, disp;
    logic [2:0]   mode_q [N];
    logic         soft_rst;
    srst_state_e  state_q, state_d;
    logic         unused_bits;

    assign word        = addr[AW-1:2];
    assign unused_bits = ^{addr[1:0], wdata};

    function automatic logic hit(input int w);
        return wr_en && (int'(word) == w);
    endfunction

    // Soft-reset sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    // Soft-reset sequencer: next state and outputs
    always_comb begin
        state_d  = state_q;
        soft_rst = 1'b0;
        unique case (state_q)
            SR_IDLE: begin
                if (hit(W_SRST) && wdata[0]) state_d = SR_ARMED;       // ARM
            end
            SR_ARMED: begin
                if (hit(W_SRST) && !wdata[0]) begin                    // FIRE
                    state_d  = SR_IDLE;
                    soft_rst = 1'b1;
                end
            end
        endcase
    end

    assign clr_bits = hit(W_CLR) ? wdata[N-1:0] : '0;
    assign status_d = (status_q & ~clr_bits) | (evt & ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0; status_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
        end else if (soft_rst) begin
            ien_q <= '0; status_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
        end else begin
            status_q <= status_d;
            if (hit(W_IEN))  ien_q  <= wdata[N-1:0];
            if (hit(W_MSET)) mask_q <= mask_q | wdata[N-1:0];
            if (hit(W_MCLR)) mask_q <= mask_q & ~wdata[N-1:0];
            if (hit(W_OUT))  out_q  <= wdata[N-1:0];
            if (hit(W_DIR))  dir_q  <= wdata[N-1:0];
        end
    end

    for (genvar p = 0; p < N; p++) begin : g_mode
        localparam int MW  = W_MODE0 + p / PINS_PER_MODE_WORD;
        localparam int LSB = 4 * (p % PINS_PER_MODE_WORD);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        mode_q[p] <= TRIG_FALL;
            else if (soft_rst) mode_q[p] <= TRIG_FALL;
            else if (hit(MW))  mode_q[p] <= wdata[LSB +: 3];
        end
        assign mode_flat[3*p +: 3] = mode_q[p];
    end

    assign disp    = status_q & ~mask_q;
    assign irq     = |disp;
    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    always_comb begin
        rdata = '0;
        case (int'(word))
            W_IEN:  rdata = DW'(ien_q);
            W_STAT: rdata = DW'(status_q);
            W_DISP: rdata = DW'(disp);
            W_MSET: rdata = DW'(mask_q);
            W_OUT:  rdata = DW'(out_q);
            W_IN:   rdata = DW'(lvl);
            W_DIR:  rdata = DW'(dir_q);
            W_SRST: rdata = DW'(state_q == SR_ARMED);
            default: begin
                for (int p = 0; p < N; p++) begin
                    if (int'(word) == W_MODE0 + p / PINS_PER_MODE_WORD)
                        rdata[4*(p % PINS_PER_MODE_WORD) +: 3] = mode_q[p];
                end
            end
        endcase
    end

    // R5
    unenabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ien_q)) == '0));

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(soft_rst) ||
                  (($past(status_q) & ~$past(clr_bits) & ~status_q) == '0)));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit(W_MSET) |=> ((mask_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    // R10
    fire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ien_q == '0 && mask_q == '0 && dir_q == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int N       = 12,
    parameter int DW      = 32,
    parameter int AW      = 6,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic          irq
);
    logic [N-1:0]   lvl;
    logic [N-1:0]   evt;
    logic [3*N-1:0] mode_flat;

    gpio_sync #(.N(N), .STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(lvl)
    );

    gpio_event_detect #(.N(N)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode_flat(mode_flat), .evt(evt)
    );

    gpio_reg_file #(.N(N), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt(evt), .lvl(lvl), .mode_flat(mode_flat),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model
    bit [11:0] m_ien, m_stat, m_mask, m_out, m_dir, m_s1, m_s2, m_d;
    bit [2:0]  m_mode [12];
    bit        m_armed;

    always @(posedge clk) begin
        bit [11:0] ev;
        bit [11:0] clr;
        int        w;
        bit        fire;
        if (!rst_n) begin
            m_ien = 0; m_stat = 0; m_mask = 0; m_out = 0; m_dir = 0;
            m_s1 = 0; m_s2 = 0; m_d = 0; m_armed = 0;
            for (int i = 0; i < 12; i++) m_mode[i] = 0;
        end else begin
            for (int i = 0; i < 12; i++) begin
                case (m_mode[i])
                    3'd0: ev[i] = m_d[i] && !m_s2[i];
                    3'd1: ev[i] = !m_d[i] && m_s2[i];
                    3'd2: ev[i] = !m_s2[i];
                    3'd3: ev[i] = m_s2[i];
                    3'd4: ev[i] = m_d[i] != m_s2[i];
                    default: ev[i] = 0;
                endcase
            end
            w    = wr_en ? int'(addr >> 2) : -1;
            clr  = (w == 3) ? wdata[11:0] : 12'h0;
            fire = (w == 15) && m_armed && !wdata[0];
            m_stat = (m_stat & ~clr) | (ev & m_ien);
            if (fire) begin
                m_ien = 0; m_stat = 0; m_mask = 0; m_out = 0; m_dir = 0; m_armed = 0;
                for (int i = 0; i < 12; i++) m_mode[i] = 0;
            end else begin
                case (w)
                    0:  m_ien  = wdata[11:0];
                    4:  m_mask = m_mask | wdata[11:0];
                    5:  m_mask = m_mask & ~wdata[11:0];
                    6:  m_out  = wdata[11:0];
                    8:  m_dir  = wdata[11:0];
                    9:  for (int i = 0; i < 8; i++) m_mode[i] = wdata[4*i +: 3];
                    10: for (int i = 8; i < 12; i++) m_mode[i] = wdata[4*(i-8) +: 3];
                    15: m_armed = wdata[0];
                    default: ;
                endcase
            end
            m_d = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic bit [31:0] mread(int w);
        bit [31:0] r = 0;
        case (w)
            0: r = 32'(m_ien);
            1: r = 32'(m_stat);
            2: r = 32'(m_stat & ~m_mask);
            4: r = 32'(m_mask);
            6: r = 32'(m_out);
            7: r = 32'(m_s2);
            8: r = 32'(m_dir);
            9: for (int i = 0; i < 8; i++) r[4*i +: 3] = m_mode[i];
            10: for (int i = 8; i < 12; i++) r[4*(i-8) +: 3] = m_mode[i];
            15: r = 32'(m_armed);
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string tag, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq == |(m_stat & ~m_mask), "R9 irq vs model", 32'(irq), 32'(|(m_stat & ~m_mask)));
            check(pin_oe == m_dir, "R2 pin_oe vs model", 32'(pin_oe), 32'(m_dir));
            check(pin_out == m_out, "R2 pin_out vs model", 32'(pin_out), 32'(m_out));
        end
    end

    task automatic wr(int w, bit [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 6'(w << 2); wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int w, bit [31:0] exp, string tag);
        addr = 6'(w << 2);
        #0.5;
        check(rdata == exp, tag, rdata, exp);
        check(rdata == mread(w), {tag, " (model)"}, rdata, mread(w));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int w = 0; w < 16; w++) rd(w, 32'h0, "R1 reset read");
        check(irq == 1'b0 && pin_oe == 0, "R1 irq/oe after reset", {irq, 19'h0, pin_oe}, 32'h0);

        // R2: direction and output
        wr(8, 32'h0F0);
        wr(6, 32'hA5A);
        check(pin_oe == 12'h0F0, "R2 pin_oe", 32'(pin_oe), 32'h0F0);
        check(pin_out == 12'hA5A, "R2 pin_out", 32'(pin_out), 32'hA5A);
        rd(8, 32'h0F0, "R2 dir readback");

        // R3: two-edge synchronizer latency, independent of direction
        pin_in = 12'h5C3;
        idle(1);
        rd(7, 32'h0, "R3 input after one edge");
        idle(1);
        rd(7, 32'h5C3, "R3 input after two edges");
        pin_in = 12'h000;
        idle(4);

        // R4: field placement, unused nibble bit
        wr(9, 32'hFFFF_FFFF);
        rd(9, 32'h7777_7777, "R4 mode0 field mask");
        wr(10, 32'hFFFF_FFFF);
        rd(10, 32'h0000_7777, "R4 mode1 field mask");
        wr(9, 32'h7654_3210);   // pins 0..7: fall,rise,low,high,both,5,6,7
        wr(10, 32'h0000_0041);  // pin8 rise, pin9 both, pins 10/11 fall
        rd(9, 32'h7654_3210, "R4 mode0 readback");

        // R5/R6: enable; pin2 low level latches
        wr(0, 32'hFFF);
        idle(2);
        rd(1, 32'h004, "R4 low level on pin2");
        wr(3, 32'hFFF);
        rd(1, 32'h004, "R6 level re-sets on clear");

        pin_in = 12'h3FF;
        idle(4);
        rd(1, 32'h31E, "R4 rising pattern status");
        wr(3, 32'hFFF);
        rd(1, 32'h008, "R6 high level re-sets on clear");
        pin_in = 12'h000;
        idle(4);
        rd(1, 32'h21D, "R4 falling pattern status");

        // R7: zero bits untouched
        wr(3, 32'h001);
        rd(1, 32'h21C, "R7 partial clear");

        // R8/R9: mask set and clear
        wr(4, 32'h21C);
        rd(4, 32'h21C, "R8 mask set");
        rd(2, 32'h000, "R9 display fully masked");
        check(irq == 1'b0, "R9 irq low when masked", 32'(irq), 32'h0);
        wr(5, 32'h004);
        rd(4, 32'h218, "R8 mask clear");
        rd(2, 32'h004, "R9 display unmasked bit");
        check(irq == 1'b1, "R9 irq high when unmasked", 32'(irq), 32'h1);

        // R5: disabled pins do not latch
        wr(0, 32'h000);
        wr(3, 32'hFFF);
        pin_in = 12'h002;
        idle(4);
        rd(1, 32'h000, "R5 no latch while disabled");
        check(irq == 1'b0, "R5 irq stays low", 32'(irq), 32'h0);

        // R10: soft reset sequence
        wr(15, 32'h0);
        rd(8, 32'h0F0, "R10 lone zero write ignored");
        rd(15, 32'h0, "R10 not armed");
        wr(15, 32'h1);
        rd(15, 32'h1, "R10 armed readback");
        rd(8, 32'h0F0, "R10 arming keeps registers");
        wr(15, 32'h0);
        rd(15, 32'h0, "R10 disarmed after fire");
        rd(8, 32'h0, "R10 dir cleared");
        rd(6, 32'h0, "R10 out cleared");
        rd(4, 32'h0, "R10 mask cleared");
        rd(9, 32'h0, "R10 mode0 cleared");
        rd(10, 32'h0, "R10 mode1 cleared");
        check(pin_oe == 0, "R10 pin_oe cleared", 32'(pin_oe), 32'h0);

        idle(2);
        finish_run();
    end
endmodule